// File: doc/BRIEF.md
# Character Display Command Executor

This block sits behind the host bus of a character display controller and carries out every host operation. Each 8-bit instruction is classified by the position of its most significant set bit. The block then updates its mode registers, moves a shared address counter, or runs a RAM sequence on the display-data RAM or the glyph RAM. Both RAMs are external to the block and are reached through synchronous single-port interfaces with one cycle of read latency.

The host presents one operation per `cmd_valid_i` pulse, described by a register select (`cmd_rs_i`: 0 = instruction, 1 = data) and a direction (`cmd_rd_i`: 1 = read). Reads return on `rd_data_o` with `rd_valid_o` one cycle after acceptance. The mode outputs (display, cursor and blink enables, line count, bus width, brightness code and horizontal scroll offset) drive the scan logic downstream. A data register holds the byte at the counter. It is refilled when an address is set and after each data read, but not after a write, so a read that directly follows a write returns the byte fetched earlier.

Top module: `char_cmd_exec`

## Requirements
- R1: After reset the block is busy for exactly 128 cycles while it writes 20h to every display RAM address. It then ends idle with display, cursor and blink off, 8-bit bus, two lines, brightness code 00, scroll offset 0, address counter 0 on display RAM, stepping up, and display scroll on writes disabled.
- R2: An instruction write is decoded by its highest set bit, and 00h has no effect. The encodings are: bit0 clear; bit1 home; bit2 entry mode (bit1 = step up, bit0 = scroll on write); bit3 on/off (bit2 display, bit1 cursor, bit0 blink); bit4 move (bit3 = scroll too, bit2 = right); bit5 function (bit4 = 8-bit bus, bit3 = two lines, bits1:0 brightness); bit6 glyph RAM address (bits5:0); bit7 display RAM address (bits6:0).
- R3: Clear keeps the block busy for 128 cycles after acceptance, writes 20h to all 128 display RAM addresses, then sets the counter to 0 on display RAM, sets the scroll offset to 0 and forces step-up.
- R4: Home sets the counter to 0, selects display RAM and sets the scroll offset to 0 in the acceptance cycle, and writes no RAM location.
- R5: While the counter points at glyph RAM it is 6 bits wide: stepping up from 3Fh gives 00h, and stepping down from 00h gives 3Fh.
- R6: On display RAM in two-line mode, stepping up goes 27h→40h and 67h→00h, and stepping down goes 40h→27h and 00h→67h. In one-line mode it wraps 4Fh→00h and 00h→4Fh.
- R7: Each accepted data read or data write steps the counter once, up when the step-up mode bit is 1 and down otherwise.
- R8: With scroll on write enabled, a display RAM data write also moves the scroll offset, by +1 when stepping up and −1 when stepping down, modulo 40. Data reads and glyph RAM writes never change the offset.
- R9: Setting an address loads the data register from that address. A data read returns the data register and then refills it from the stepped address. A data write does not refill it.
- R10: Busy is high from the cycle after accepting a clear, address set, data read or data write until it completes. During that time only status reads are served, returning busy in bit7 and the counter in bits6:0. Every other operation is dropped without effect.
- R11: The move instruction steps the cursor one position right (bit2 = 1) or left, using the R6 rules. When bit3 is 1 it also moves the scroll offset the same way (right = −1, left = +1, modulo 40).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Host operation strobe, one cycle |
| cmd_rs_i | input | 1 | 0 = instruction/status, 1 = data |
| cmd_rd_i | input | 1 | 1 = read, 0 = write |
| cmd_data_i | input | 8 | Instruction code or write data |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | 8 | Read result (status or data register) |
| busy_o | output | 1 | Internal operation in progress |
| dd_req_o | output | 1 | Display RAM access strobe |
| dd_we_o | output | 1 | Display RAM write enable |
| dd_addr_o | output | 7 | Display RAM address |
| dd_wdata_o | output | 8 | Display RAM write data |
| dd_rdata_i | input | 8 | Display RAM read data, one cycle after request |
| cg_req_o | output | 1 | Glyph RAM access strobe |
| cg_we_o | output | 1 | Glyph RAM write enable |
| cg_addr_o | output | 6 | Glyph RAM address |
| cg_wdata_o | output | 8 | Glyph RAM write data |
| cg_rdata_i | input | 8 | Glyph RAM read data, one cycle after request |
| disp_on_o | output | 1 | Display enable |
| cursor_on_o | output | 1 | Cursor enable |
| blink_on_o | output | 1 | Blink enable |
| two_line_o | output | 1 | Two-line mode |
| wide_bus_o | output | 1 | 8-bit host bus selected |
| bright_o | output | 2 | Brightness code |
| shift_ofs_o | output | 6 | Scroll offset, 0 to 39 |

## Verification
A wrong counter step or a missed line jump shows at the next status read, which reports the counter one cycle after acceptance. It also shows at the RAM address of the next data write. A stale or wrongly refilled data register shows on the very next data read, and it can sit hidden until that read. A wrong scroll offset shows on `shift_ofs_o` one cycle after the write or move. A clear or reset sequence that is too short or too long shows in the busy window length, and in any display RAM address left without 20h.

// File: rtl/char_exec_pkg.sv
package char_exec_pkg;
  localparam int DW = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CLR, ST_WR, ST_FETCH, ST_CAP
  } exec_state_e;

  // index of the leading one in the instruction code
  typedef enum logic [2:0] {
    OP_CLEAR  = 3'd0,
    OP_HOME   = 3'd1,
    OP_ENTRY  = 3'd2,
    OP_ONOFF  = 3'd3,
    OP_MOVE   = 3'd4,
    OP_FUNC   = 3'd5,
    OP_CGADDR = 3'd6,
    OP_DDADDR = 3'd7
  } op_e;
endpackage

// File: rtl/char_cmd_decode.sv
module char_cmd_decode
  import char_exec_pkg::*;
(
  input  logic [DW-1:0] code_i,
  output op_e           op_o,
  output logic          op_valid_o
);
  localparam int IW = $clog2(DW);
  logic [IW-1:0] lead;

  always_comb begin
    lead       = '0;
    op_valid_o = 1'b0;
    for (int b = 0; b < DW; b++) begin
      if (code_i[b]) begin
        lead       = IW'(b);
        op_valid_o = 1'b1;
      end
    end
  end

  assign op_o = op_e'(lead);
endmodule

// File: rtl/char_addr_step.sv
module char_addr_step #(
  parameter int DD_AW        = 7,
  parameter int CG_AW        = 6,
  parameter int LINE_LEN     = 40,
  parameter int LINE2_BASE   = 64,
  parameter int ONE_LINE_LEN = 80
) (
  input  logic [DD_AW-1:0] addr_i,
  input  logic             up_i,
  input  logic             cg_sel_i,
  input  logic             two_line_i,
  output logic [DD_AW-1:0] addr_o
);
  localparam logic [DD_AW-1:0] L1_LAST  = DD_AW'(LINE_LEN - 1);
  localparam logic [DD_AW-1:0] L2_FIRST = DD_AW'(LINE2_BASE);
  localparam logic [DD_AW-1:0] L2_LAST  = DD_AW'(LINE2_BASE + LINE_LEN - 1);
  localparam logic [DD_AW-1:0] SGL_LAST = DD_AW'(ONE_LINE_LEN - 1);
  localparam logic [DD_AW-1:0] ONE      = DD_AW'(1);

  logic [CG_AW-1:0] cg_next;

  always_comb begin
    cg_next = up_i ? addr_i[CG_AW-1:0] + 1'b1 : addr_i[CG_AW-1:0] - 1'b1;
    if (cg_sel_i) begin
      addr_o = {{(DD_AW-CG_AW){1'b0}}, cg_next};
    end else if (two_line_i) begin
      if (up_i) addr_o = (addr_i == L1_LAST) ? L2_FIRST :
                         (addr_i == L2_LAST) ? '0 : addr_i + ONE;
      else      addr_o = (addr_i == '0)       ? L2_LAST :
                         (addr_i == L2_FIRST) ? L1_LAST : addr_i - ONE;
    end else begin
      if (up_i) addr_o = (addr_i == SGL_LAST) ? '0 : addr_i + ONE;
      else      addr_o = (addr_i == '0) ? SGL_LAST : addr_i - ONE;
    end
  end
endmodule

// File: rtl/char_cmd_exec.sv
module char_cmd_exec
  import char_exec_pkg::*;
#(
  parameter int             DD_AW        = 7,
  parameter int             CG_AW        = 6,
  parameter int             LINE_LEN     = 40,
  parameter int             LINE2_BASE   = 64,
  parameter int             ONE_LINE_LEN = 80,
  parameter logic [DW-1:0]  BLANK_CODE   = 8'h20,
  localparam int            OFS_W        = $clog2(LINE_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic             cmd_rs_i,
  input  logic             cmd_rd_i,
  input  logic [DW-1:0]    cmd_data_i,
  output logic             rd_valid_o,
  output logic [DW-1:0]    rd_data_o,
  output logic             busy_o,
  output logic             dd_req_o,
  output logic             dd_we_o,
  output logic [DD_AW-1:0] dd_addr_o,
  output logic [DW-1:0]    dd_wdata_o,
  input  logic [DW-1:0]    dd_rdata_i,
  output logic             cg_req_o,
  output logic             cg_we_o,
  output logic [CG_AW-1:0] cg_addr_o,
  output logic [DW-1:0]    cg_wdata_o,
  input  logic [DW-1:0]    cg_rdata_i,
  output logic             disp_on_o,
  output logic             cursor_on_o,
  output logic             blink_on_o,
  output logic             two_line_o,
  output logic             wide_bus_o,
  output logic [1:0]       bright_o,
  output logic [OFS_W-1:0] shift_ofs_o
);
  localparam logic [DD_AW-1:0] CLR_LAST = '1;
  localparam logic [OFS_W-1:0] OFS_LAST = OFS_W'(LINE_LEN - 1);
  localparam logic [DD_AW-1:0] L1_LAST  = DD_AW'(LINE_LEN - 1);
  localparam logic [DD_AW-1:0] L2_FIRST = DD_AW'(LINE2_BASE);

  exec_state_e      state;
  logic [DD_AW-1:0] clr_cnt, ac, ac_step;
  logic             sel_cg, step_up_mode, scroll_wr;
  logic [DW-1:0]    data_reg, wbuf;
  logic [OFS_W-1:0] ofs, ofs_left, ofs_right;
  op_e              op;
  logic             op_valid, acc_status, acc_op, step_up;

  assign busy_o     = (state != ST_IDLE);
  assign acc_status = cmd_valid_i && !cmd_rs_i && cmd_rd_i;
  assign acc_op     = cmd_valid_i && !busy_o && !acc_status;

  char_cmd_decode u_dec (
    .code_i     (cmd_data_i),
    .op_o       (op),
    .op_valid_o (op_valid)
  );

  // move instruction picks direction from its own bit, data access from entry mode
  assign step_up = (acc_op && !cmd_rs_i && op_valid && op == OP_MOVE) ? cmd_data_i[2]
                                                                       : step_up_mode;

  char_addr_step #(
    .DD_AW(DD_AW), .CG_AW(CG_AW), .LINE_LEN(LINE_LEN),
    .LINE2_BASE(LINE2_BASE), .ONE_LINE_LEN(ONE_LINE_LEN)
  ) u_step (
    .addr_i     (ac),
    .up_i       (step_up),
    .cg_sel_i   (sel_cg),
    .two_line_i (two_line_o),
    .addr_o     (ac_step)
  );

  assign ofs_left  = (ofs == OFS_LAST) ? '0 : ofs + 1'b1;
  assign ofs_right = (ofs == '0) ? OFS_LAST : ofs - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state        <= ST_CLR;
      clr_cnt      <= '0;
      ac           <= '0;
      sel_cg       <= 1'b0;
      step_up_mode <= 1'b1;
      scroll_wr    <= 1'b0;
      disp_on_o    <= 1'b0;
      cursor_on_o  <= 1'b0;
      blink_on_o   <= 1'b0;
      wide_bus_o   <= 1'b1;
      two_line_o   <= 1'b1;
      bright_o     <= 2'b00;
      ofs          <= '0;
      data_reg     <= '0;
      wbuf         <= '0;
      rd_data_o    <= '0;
      rd_valid_o   <= 1'b0;
    end else begin
      rd_valid_o <= 1'b0;
      if (acc_status) begin
        rd_data_o  <= DW'({busy_o, ac});
        rd_valid_o <= 1'b1;
      end
      unique case (state)
        ST_IDLE: if (acc_op) begin
          if (cmd_rs_i) begin
            if (cmd_rd_i) begin
              rd_data_o  <= data_reg;
              rd_valid_o <= 1'b1;
              ac         <= ac_step;
              state      <= ST_FETCH;
            end else begin
              wbuf  <= cmd_data_i;
              state <= ST_WR;
            end
          end else if (op_valid) begin
            unique case (op)
              OP_CLEAR: begin
                clr_cnt <= '0;
                state   <= ST_CLR;
              end
              OP_HOME: begin
                ac     <= '0;
                sel_cg <= 1'b0;
                ofs    <= '0;
              end
              OP_ENTRY: begin
                step_up_mode <= cmd_data_i[1];
                scroll_wr    <= cmd_data_i[0];
              end
              OP_ONOFF: begin
                disp_on_o   <= cmd_data_i[2];
                cursor_on_o <= cmd_data_i[1];
                blink_on_o  <= cmd_data_i[0];
              end
              OP_MOVE: begin
                ac <= ac_step;
                if (cmd_data_i[3]) ofs <= cmd_data_i[2] ? ofs_right : ofs_left;
              end
              OP_FUNC: begin
                wide_bus_o <= cmd_data_i[4];
                two_line_o <= cmd_data_i[3];
                bright_o   <= cmd_data_i[1:0];
              end
              OP_CGADDR: begin
                ac     <= {{(DD_AW-CG_AW){1'b0}}, cmd_data_i[CG_AW-1:0]};
                sel_cg <= 1'b1;
                state  <= ST_FETCH;
              end
              OP_DDADDR: begin
                ac     <= cmd_data_i[DD_AW-1:0];
                sel_cg <= 1'b0;
                state  <= ST_FETCH;
              end
            endcase
          end
        end
        ST_WR: begin
          ac <= ac_step;
          if (scroll_wr && !sel_cg) ofs <= step_up_mode ? ofs_left : ofs_right;
          state <= ST_IDLE;
        end
        ST_FETCH: state <= ST_CAP;
        ST_CAP: begin
          data_reg <= sel_cg ? cg_rdata_i : dd_rdata_i;
          state    <= ST_IDLE;
        end
        ST_CLR: begin
          clr_cnt <= clr_cnt + 1'b1;
          if (clr_cnt == CLR_LAST) begin
            ac           <= '0;
            sel_cg       <= 1'b0;
            ofs          <= '0;
            step_up_mode <= 1'b1;
            state        <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign dd_req_o    = (state == ST_CLR) || ((state == ST_WR || state == ST_FETCH) && !sel_cg);
  assign dd_we_o     = (state == ST_CLR) || (state == ST_WR && !sel_cg);
  assign dd_addr_o   = (state == ST_CLR) ? clr_cnt : ac;
  assign dd_wdata_o  = (state == ST_CLR) ? BLANK_CODE : wbuf;
  assign cg_req_o    = (state == ST_WR || state == ST_FETCH) && sel_cg;
  assign cg_we_o     = (state == ST_WR) && sel_cg;
  assign cg_addr_o   = ac[CG_AW-1:0];
  assign cg_wdata_o  = wbuf;
  assign shift_ofs_o = ofs;

  assert_clear_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_CLR && clr_cnt == CLR_LAST) |=> (ac == '0 && ofs == '0 && step_up_mode && !busy_o));

  assert_cg_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_cg |-> (ac[DD_AW-1:CG_AW] == '0));

  assert_line_jump_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WR && !sel_cg && two_line_o && step_up_mode && ac == L1_LAST) |=> (ac == L2_FIRST));

  assert_ofs_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ofs <= OFS_LAST);

  assert_rd_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(cmd_valid_i && cmd_rd_i));

  assert_busy_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmd_valid_i && !cmd_rd_i) |=>
      $stable({disp_on_o, cursor_on_o, blink_on_o, wide_bus_o, two_line_o, bright_o, scroll_wr}));
endmodule

// File: tb/tb_char_cmd_exec.sv
module tb_char_cmd_exec;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid, cmd_rs, cmd_rd;
  logic [7:0] cmd_data;
  logic       rd_valid, busy;
  logic [7:0] rd_data;
  logic       dd_req, dd_we, cg_req, cg_we;
  logic [6:0] dd_addr;
  logic [5:0] cg_addr;
  logic [7:0] dd_wdata, cg_wdata, dd_q, cg_q;
  logic       disp_on, cursor_on, blink_on, two_line, wide_bus;
  logic [1:0] bright;
  logic [5:0] ofs;

  logic [7:0] dd_mem [128];
  logic [7:0] cg_mem [64];
  logic [7:0] snap   [128];

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  char_cmd_exec dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_rs_i(cmd_rs), .cmd_rd_i(cmd_rd), .cmd_data_i(cmd_data),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .busy_o(busy),
    .dd_req_o(dd_req), .dd_we_o(dd_we), .dd_addr_o(dd_addr), .dd_wdata_o(dd_wdata), .dd_rdata_i(dd_q),
    .cg_req_o(cg_req), .cg_we_o(cg_we), .cg_addr_o(cg_addr), .cg_wdata_o(cg_wdata), .cg_rdata_i(cg_q),
    .disp_on_o(disp_on), .cursor_on_o(cursor_on), .blink_on_o(blink_on),
    .two_line_o(two_line), .wide_bus_o(wide_bus), .bright_o(bright), .shift_ofs_o(ofs)
  );

  // synchronous RAM models, one cycle read latency
  always @(posedge clk) begin
    if (dd_req) begin
      if (dd_we) dd_mem[dd_addr] <= dd_wdata;
      else       dd_q <= dd_mem[dd_addr];
    end
    if (cg_req) begin
      if (cg_we) cg_mem[cg_addr] <= cg_wdata;
      else       cg_q <= cg_mem[cg_addr];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic op(input logic rs, input logic rd, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_rs = rs; cmd_rd = rd; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] d);
    op(1'b0, 1'b0, d); wait_idle();
  endtask

  task automatic wr(input logic [7:0] d);
    op(1'b1, 1'b0, d); wait_idle();
  endtask

  task automatic status(output logic [7:0] s);
    op(1'b0, 1'b1, 8'h00); s = rd_data; wait_idle();
  endtask

  function automatic int blank_miss();
    int n = 0;
    for (int i = 0; i < 128; i++) if (dd_mem[i] !== 8'h20) n++;
    return n;
  endfunction

  // {rs, rd, check, data, expected read}
  localparam int NV = 16;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 8'h80, 8'h00},  // DD address 0
    {1'b1, 1'b0, 1'b0, 8'h41, 8'h00},
    {1'b1, 1'b0, 1'b0, 8'h42, 8'h00},
    {1'b0, 1'b1, 1'b1, 8'h00, 8'h02},  // R7 default step-up
    {1'b0, 1'b0, 1'b0, 8'h80, 8'h00},
    {1'b1, 1'b1, 1'b1, 8'h00, 8'h41},  // R9 loaded by address set
    {1'b1, 1'b1, 1'b1, 8'h00, 8'h42},  // R9 prefetch
    {1'b0, 1'b1, 1'b1, 8'h00, 8'h02},
    {1'b1, 1'b0, 1'b0, 8'h43, 8'h00},
    {1'b1, 1'b1, 1'b1, 8'h00, 8'h20},  // R9 stale after write
    {1'b0, 1'b1, 1'b1, 8'h00, 8'h04},
    {1'b0, 1'b0, 1'b0, 8'h42, 8'h00},  // CG address 2
    {1'b1, 1'b0, 1'b0, 8'h15, 8'h00},
    {1'b0, 1'b0, 1'b0, 8'h42, 8'h00},
    {1'b1, 1'b1, 1'b1, 8'h00, 8'h15},  // R9 glyph RAM
    {1'b0, 1'b1, 1'b1, 8'h00, 8'h03}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] s;
    int n;
    cmd_valid = 1'b0; cmd_rs = 1'b0; cmd_rd = 1'b0; cmd_data = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 1'b1);
    chk("R1 no read in reset", rd_valid, 1'b0);
    rst_n = 1'b1;
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R1 reset clear length", n, 128);
    chk("R1 reset RAM blank misses", blank_miss(), 0);
    chk("R1 on/off flags", {disp_on, cursor_on, blink_on}, 3'b000);
    chk("R1 function fields", {wide_bus, two_line, bright}, 4'b1100);
    chk("R1 scroll offset", ofs, 0);
    status(s);
    chk("R1 status", s, 8'h00);

    for (int i = 0; i < NV; i++) begin
      op(VEC[i][18], VEC[i][17], VEC[i][15:8]);
      if (VEC[i][16]) chk($sformatf("R9 vector %0d", i), rd_data, VEC[i][7:0]);
      wait_idle();
    end
    chk("R9 glyph RAM content", cg_mem[2], 8'h15);

    // R2 decode
    cmd(8'h00); status(s);
    chk("R2 zero code no effect", s, 8'h03);
    cmd(8'h0F); chk("R2 on/off all", {disp_on, cursor_on, blink_on}, 3'b111);
    cmd(8'h0A); chk("R2 on/off cursor only", {disp_on, cursor_on, blink_on}, 3'b010);
    cmd(8'h2B); chk("R2 function 4-bit", {wide_bus, two_line, bright}, 4'b0111);
    cmd(8'h38); chk("R2 function restore", {wide_bus, two_line, bright}, 4'b1100);

    // R5 glyph wrap
    cmd(8'h7F); wr(8'h01); status(s);
    chk("R5 glyph wrap up", s, 8'h00);
    cmd(8'h04); cmd(8'h40); wr(8'h02); status(s);
    chk("R5 glyph wrap down", s, 8'h3F);
    cmd(8'h06);

    // R6 display RAM stepping
    cmd(8'hA7); wr(8'h61); status(s); chk("R6 27h up to 40h", s, 8'h40);
    cmd(8'hE7); wr(8'h62); status(s); chk("R6 67h up to 00h", s, 8'h00);
    cmd(8'h04);
    cmd(8'hC0); wr(8'h63); status(s); chk("R6 40h down to 27h", s, 8'h27);
    cmd(8'h80); wr(8'h64); status(s); chk("R6 00h down to 67h", s, 8'h67);
    cmd(8'h06); cmd(8'h30);
    cmd(8'hCF); wr(8'h65); status(s); chk("R6 one-line 4Fh up", s, 8'h00);
    cmd(8'h04); wr(8'h66); status(s); chk("R6 one-line 00h down R7", s, 8'h4F);
    cmd(8'h06); cmd(8'h38);

    // R8 scroll on write
    cmd(8'h07); cmd(8'h80); wr(8'h70);
    chk("R8 scroll left on write", ofs, 1);
    status(s); chk("R8 counter still steps", s, 8'h01);
    cmd(8'h05); wr(8'h71); chk("R8 scroll back", ofs, 0);
    wr(8'h72); chk("R8 scroll wraps to 39", ofs, 39);
    op(1'b1, 1'b1, 8'h00); wait_idle();
    chk("R8 read does not scroll", ofs, 39);
    cmd(8'h40); wr(8'h73); chk("R8 glyph write does not scroll", ofs, 39);
    cmd(8'h06);

    // R4 home
    for (int i = 0; i < 128; i++) snap[i] = dd_mem[i];
    cmd(8'h02);
    n = 0;
    for (int i = 0; i < 128; i++) if (dd_mem[i] !== snap[i]) n++;
    chk("R4 home RAM untouched", n, 0);
    chk("R4 home offset", ofs, 0);
    status(s); chk("R4 home counter", s, 8'h00);
    wr(8'h55); chk("R4 home selects display RAM", dd_mem[0], 8'h55);

    // R11 move instruction
    cmd(8'h80);
    cmd(8'h1C); status(s); chk("R11 scroll right counter", s, 8'h01);
    chk("R11 scroll right offset", ofs, 39);
    cmd(8'h18); status(s); chk("R11 scroll left counter", s, 8'h00);
    chk("R11 scroll left offset", ofs, 0);
    cmd(8'h14); status(s); chk("R11 cursor right", s, 8'h01);
    chk("R11 cursor only keeps offset", ofs, 0);
    cmd(8'h10); cmd(8'h10); status(s); chk("R11 cursor left wraps to 67h", s, 8'h67);

    // R3 clear
    cmd(8'h04); cmd(8'h1C);
    op(1'b0, 1'b0, 8'h01);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R3 clear length", n, 128);
    chk("R3 clear RAM blank misses", blank_miss(), 0);
    chk("R3 clear offset", ofs, 0);
    status(s); chk("R3 clear counter", s, 8'h00);
    wr(8'h77); status(s); chk("R3 clear forces step-up", s, 8'h01);

    // R10 busy behaviour
    op(1'b0, 1'b0, 8'h01);
    op(1'b0, 1'b0, 8'h0F);
    op(1'b1, 1'b0, 8'h99);
    op(1'b1, 1'b1, 8'h00);
    chk("R10 data read dropped", rd_valid, 1'b0);
    op(1'b0, 1'b1, 8'h00);
    chk("R10 status while busy valid", rd_valid, 1'b1);
    chk("R10 status busy bit", rd_data[7], 1'b1);
    wait_idle();
    chk("R10 on/off dropped", {disp_on, cursor_on, blink_on}, 3'b010);
    chk("R10 write dropped", blank_miss(), 0);
    status(s); chk("R10 counter unmoved", s, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule